// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is an on-chip synchronous memory with a fixed two-cycle pipeline for both directions. A command (address, read/write, chip select) is captured on a clock edge where the advance input is low. A read returns its word two enabled edges later. A write takes its data and byte-lane enables two enabled edges after the command. Because reads and writes share the same latency, any mix of commands can be issued on consecutive cycles without idle cycles on the shared data path.

The word holds two lanes. Each lane has eight data bits and one parity bit, and each lane has its own active-low write enable. Storage is held in a synchronous-read array. A write that commits on the same edge that a younger read samples the array is forwarded lane by lane into that read's result. A registered clock enable freezes the whole pipeline. An asynchronous output enable and a sleep input gate only the output drive. The bidirectional bus is split into separate input, output and drive-enable signals.

Top module: `ntsram_core`

## Requirements
- R1: Lane 0 is data bits 7..0 with parity bit 0, written only when `lane_we_n[0]` is low. Lane 1 is data bits 15..8 with parity bit 1, written only when `lane_we_n[1]` is low. A lane that is not written keeps its stored value.
- R2: A read command captured at an enabled edge E has its word on `dq_o`/`dqp_o` with `dq_oe` high after the second enabled edge following E.
- R3: For a write command captured at enabled edge E, the data and lane enables present at the second enabled edge after E are written to the captured address.
- R4: A write whose two lane enables are both high at its data edge changes no storage, and the output stays undriven after that edge.
- R5: While `clk_en_n` is high, edges are ignored. Pipeline state and outputs hold, and no write is performed.
- R6: The block is selected only when `cs1_n` and `cs2_n` are low and `cs3` is high. Select is sampled only on advance-low edges. A deselected command leaves the output undriven two enabled edges later.
- R7: `out_en_n` high forces `dq_oe` low at once, without a clock edge, and does not disturb the pipeline.
- R8: While `sleep` is high, `dq_oe` is low, the pipeline is emptied and storage is retained. After release, operation resumes with the next advance-low command.
- R9: A read issued on the cycle right after a write to the same address returns the new data in the written lanes and the old data in the other lanes.
- R10: Reset empties the pipeline and leaves the output undriven. It does not clear storage.
- R11: An enabled edge with `adv_n` high issues no command, and the output is undriven two enabled edges later.
- R12: Reads and writes to any addresses may alternate on consecutive cycles, each with the latency given in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable |
| adv_n | input | 1 | Low: capture a new command |
| wr_n | input | 1 | Low: write command, high: read |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| dq_i | input | LANES*BYTE_W | Write data |
| dqp_i | input | LANES | Write parity |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request |
| dq_o | output | LANES*BYTE_W | Read data |
| dqp_o | output | LANES | Read parity |
| dq_oe | output | 1 | High when the bus is driven |

## Verification
Read data and the drive enable are due after the second enabled edge that follows the command. Write data is consumed at that same edge, so the effect of a write becomes visible through a later read. The bench keeps an untimed reference memory and a queue of commands that advances only on enabled, non-sleeping edges. On every cycle it compares the outputs at the falling edge against the entry leaving the queue. This covers frozen edges, deselects and the forwarding case with no special timing code. The asynchronous output enable is checked a few time units after it changes, with no clock edge in between.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ntsram_ctl.sv
module ntsram_ctl
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              sleep,
  input  logic              adv_n,
  input  logic              wr_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               s1_op_o,
  output logic [ADDR_W-1:0] s1_addr_o,
  output op_e               s2_op_o,
  output logic [ADDR_W-1:0] s2_addr_o
);
  op_e               s1_q, s2_q, s1_n, s2_n, cap_op;
  logic [ADDR_W-1:0] a1_q, a2_q, a1_n, a2_n;

  always_comb begin
    if (!adv_n && sel) cap_op = wr_n ? OP_READ : OP_WRITE;
    else               cap_op = OP_IDLE;
    s1_n = s1_q;
    s2_n = s2_q;
    a1_n = a1_q;
    a2_n = a2_q;
    if (sleep) begin
      s1_n = OP_IDLE;
      s2_n = OP_IDLE;
    end else if (cke) begin
      s1_n = cap_op;
      s2_n = s1_q;
      a2_n = a1_q;
      if (!adv_n) a1_n = addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= OP_IDLE;
      s2_q <= OP_IDLE;
    end else begin
      s1_q <= s1_n;
      s2_q <= s2_n;
    end
  end

  always_ff @(posedge clk) begin
    a1_q <= a1_n;
    a2_q <= a2_n;
  end

  assign s1_op_o   = s1_q;
  assign s1_addr_o = a1_q;
  assign s2_op_o   = s2_q;
  assign s2_addr_o = a2_q;

  // R5: a held clock freezes the command stages
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !sleep) |=> ($stable(s1_q) && $stable(s2_q) && $stable(a2_q)));
  // R11: advance high issues nothing
  assert_adv_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !sleep && adv_n) |=> (s1_q == OP_IDLE));
  // R6: deselected capture issues nothing
  assert_desel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !sleep && !adv_n && !sel) |=> (s1_q == OP_IDLE));
  // R8: sleep empties both stages
  assert_sleep_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (s1_q == OP_IDLE && s2_q == OP_IDLE));
endmodule

// File: rtl/ntsram_array.sv
module ntsram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] rq;

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      if (rd_en) rq <= bank[rd_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rq;
  end
endmodule

// File: rtl/ntsram_dout.sv
module ntsram_dout
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    sleep,
  input  op_e                     s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES*LANE_W-1:0] arr_data,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    drive
);
  localparam int WORD_W = LANES * LANE_W;

  logic              byp_hit_q, byp_hit_n, drive_q, drive_n;
  logic [LANES-1:0]  byp_mask_q, byp_mask_n;
  logic [WORD_W-1:0] byp_data_q, byp_data_n, dout_q, dout_n, merged;

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (byp_hit_q && byp_mask_q[g]) ?
        byp_data_q[g*LANE_W +: LANE_W] : arr_data[g*LANE_W +: LANE_W];
  end

  always_comb begin
    byp_hit_n  = byp_hit_q;
    byp_mask_n = byp_mask_q;
    byp_data_n = byp_data_q;
    dout_n     = dout_q;
    drive_n    = drive_q;
    if (cke) begin
      byp_hit_n  = (s1_op == OP_READ) && (s2_op == OP_WRITE) &&
                   (s1_addr == s2_addr) && (|wr_mask);
      byp_mask_n = wr_mask;
      byp_data_n = wr_data;
      drive_n    = (s2_op == OP_READ);
      if (s2_op == OP_READ) dout_n = merged;
    end
    if (sleep) begin
      byp_hit_n = 1'b0;
      drive_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_hit_q <= 1'b0;
      drive_q   <= 1'b0;
    end else begin
      byp_hit_q <= byp_hit_n;
      drive_q   <= drive_n;
    end
  end

  always_ff @(posedge clk) begin
    byp_mask_q <= byp_mask_n;
    byp_data_q <= byp_data_n;
    dout_q     <= dout_n;
  end

  assign dout  = dout_q;
  assign drive = drive_q;

  // R2: a read leaving the second stage drives the bus next cycle
  assert_read_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !sleep && s2_op == OP_READ) |=> drive_q);
  // R3/R4: a write leaving the second stage never drives the bus
  assert_write_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !sleep && s2_op == OP_WRITE) |=> !drive_q);
endmodule

// File: rtl/ntsram_core.sv
module ntsram_core
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    adv_n,
  input  logic                    wr_n,
  input  logic                    cs1_n,
  input  logic                    cs2_n,
  input  logic                    cs3,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*BYTE_W-1:0] dq_i,
  input  logic [LANES-1:0]        dqp_i,
  input  logic                    out_en_n,
  input  logic                    sleep,
  output logic [LANES*BYTE_W-1:0] dq_o,
  output logic [LANES-1:0]        dqp_o,
  output logic                    dq_oe
);
  localparam int LANE_W = BYTE_W + 1;
  localparam int WORD_W = LANES * LANE_W;

  logic              cke, sel, wr_en, drive;
  logic [LANES-1:0]  wr_mask;
  logic [WORD_W-1:0] wr_word, rd_word, out_word;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;

  assign cke     = !clk_en_n;
  assign sel     = !cs1_n && !cs2_n && cs3;
  assign wr_mask = ~lane_we_n;
  assign wr_en   = cke && !sleep && (s2_op == OP_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign wr_word[g*LANE_W +: LANE_W] = {dqp_i[g], dq_i[g*BYTE_W +: BYTE_W]};
    assign dq_o[g*BYTE_W +: BYTE_W]    = out_word[g*LANE_W +: BYTE_W];
    assign dqp_o[g]                    = out_word[g*LANE_W + BYTE_W];
  end

  ntsram_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cke(cke), .sleep(sleep), .adv_n(adv_n),
    .wr_n(wr_n), .sel(sel), .addr_i(addr),
    .s1_op_o(s1_op), .s1_addr_o(s1_addr), .s2_op_o(s2_op), .s2_addr_o(s2_addr)
  );

  ntsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rd_en(cke && !sleep), .rd_addr(s1_addr),
    .wr_en(wr_en), .wr_addr(s2_addr), .wr_mask(wr_mask),
    .wr_data(wr_word), .rd_data(rd_word)
  );

  ntsram_dout #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dout (
    .clk(clk), .rst_n(rst_n), .cke(cke), .sleep(sleep),
    .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op), .s2_addr(s2_addr),
    .wr_mask(wr_mask), .wr_data(wr_word), .arr_data(rd_word),
    .dout(out_word), .drive(drive)
  );

  assign dq_oe = drive && !out_en_n && !sleep;

  // R10: while reset is held the bus is never driven
  assert_reset_hiz_R10: assert property (@(posedge clk) !rst_n |-> !dq_oe);
endmodule

// File: tb/tb_ntsram_core.sv
module tb_ntsram_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst_n, clk_en_n, adv_n, wr_n, cs1_n, cs2_n, cs3, out_en_n, sleep;
  logic [AW-1:0] addr;
  logic [1:0]  lane_we_n, dqp_i, dqp_o;
  logic [15:0] dq_i, dq_o;
  logic        dq_oe;

  ntsram_core dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_n(adv_n), .wr_n(wr_n),
    .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3), .addr(addr), .lane_we_n(lane_we_n),
    .dq_i(dq_i), .dqp_i(dqp_i), .out_en_n(out_en_n), .sleep(sleep),
    .dq_o(dq_o), .dqp_o(dqp_o), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  bit    finished = 0;
  string tag = "R10";

  // reference model
  logic [15:0] md [int];
  logic [1:0]  mp [int];
  int          mq_op[$], mq_a[$];
  logic        exp_drive = 1'b0;
  logic [15:0] exp_d = '0;
  logic [1:0]  exp_p = '0;

  // write-data delivery line (two enabled cycles of lag)
  logic [1:0]  dl_bw[$];
  logic [15:0] dl_d[$];
  logic [1:0]  dl_p[$];

  function automatic void flush();
    mq_op = '{0, 0};
    mq_a  = '{0, 0};
    dl_bw = '{2'b11, 2'b11};
    dl_d  = '{16'h0, 16'h0};
    dl_p  = '{2'b00, 2'b00};
    exp_drive = 1'b0;
  endfunction

  function automatic void model_edge();
    int op, a0, op0;
    if (!rst_n || sleep) begin
      mq_op = '{0, 0};
      mq_a  = '{0, 0};
      exp_drive = 1'b0;
    end else if (!clk_en_n) begin
      op = (!adv_n && !cs1_n && !cs2_n && cs3) ? (wr_n ? 1 : 2) : 0;
      mq_op.push_back(op);
      mq_a.push_back(int'(addr));
      op0 = mq_op.pop_front();
      a0  = mq_a.pop_front();
      exp_drive = (op0 == 1);
      if (op0 == 1) begin
        exp_d = md.exists(a0) ? md[a0] : 16'h0;
        exp_p = mp.exists(a0) ? mp[a0] : 2'b0;
      end else if (op0 == 2) begin
        if (!md.exists(a0)) begin md[a0] = 16'h0; mp[a0] = 2'b0; end
        if (!lane_we_n[0]) begin md[a0][7:0]  = dq_i[7:0];  mp[a0][0] = dqp_i[0]; end
        if (!lane_we_n[1]) begin md[a0][15:8] = dq_i[15:8]; mp[a0][1] = dqp_i[1]; end
      end
    end
  endfunction

  task automatic check_now();
    logic exp_oe;
    exp_oe = exp_drive && !out_en_n && !sleep;
    n_chk++;
    if (dq_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s: dq_oe=%0b expected %0b at %0t", tag, dq_oe, exp_oe, $time);
    end else if (exp_oe && (dq_o !== exp_d || dqp_o !== exp_p)) begin
      n_bad++;
      $display("FAIL %s: data=%h/%b expected %h/%b at %0t", tag, dq_o, dqp_o, exp_d, exp_p, $time);
    end
  endtask

  task automatic cyc(input bit hold, input bit adv, input bit wr, input int a,
                     input logic [1:0] bw, input logic [15:0] d, input logic [1:0] p);
    clk_en_n  = hold;
    adv_n     = !adv;
    wr_n      = !wr;
    addr      = a[AW-1:0];
    lane_we_n = dl_bw[0];
    dq_i      = dl_d[0];
    dqp_i     = dl_p[0];
    @(posedge clk);
    model_edge();
    if (!rst_n || sleep) begin
      dl_bw = '{2'b11, 2'b11};
      dl_d  = '{16'h0, 16'h0};
      dl_p  = '{2'b00, 2'b00};
    end else if (!hold) begin
      void'(dl_bw.pop_front()); void'(dl_d.pop_front()); void'(dl_p.pop_front());
      dl_bw.push_back((adv && wr) ? bw : 2'b11);
      dl_d.push_back(d);
      dl_p.push_back(p);
    end
    @(negedge clk);
    check_now();
  endtask

  function automatic logic [15:0] dat(input int a, input int s);
    return 16'((a * 16'h1f3) ^ (s * 16'h5a5) ^ 16'hc3e1);
  endfunction

  task automatic wr_cmd(input int a, input logic [1:0] bw, input int s);
    cyc(0, 1, 1, a, bw, dat(a, s), 2'(a + s));
  endtask
  task automatic rd_cmd(input int a);
    cyc(0, 1, 0, a, 2'b11, 16'h0, 2'b0);
  endtask
  task automatic nop();
    cyc(0, 0, 0, 0, 2'b11, 16'h0, 2'b0);
  endtask
  task automatic hold_cyc();
    cyc(1, 1, 0, 0, 2'b11, 16'h0, 2'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clk_en_n = 0; adv_n = 1; wr_n = 1; cs1_n = 0; cs2_n = 0; cs3 = 1;
    addr = '0; lane_we_n = 2'b11; dq_i = '0; dqp_i = '0; out_en_n = 0; sleep = 0;
    flush();
    // R10: reset state, output undriven
    tag = "R10";
    repeat (3) nop();
    rst_n = 1;
    nop();

    // R3: back-to-back full writes
    tag = "R3";
    for (int i = 0; i < 16; i++) wr_cmd(i, 2'b00, 1);
    // R2: back-to-back reads
    tag = "R2";
    for (int i = 0; i < 16; i++) rd_cmd(i);
    nop(); nop();

    // R12: alternating writes and reads
    tag = "R12";
    for (int i = 0; i < 8; i++) begin wr_cmd(20 + i, 2'b00, 2); rd_cmd(i); end
    for (int i = 0; i < 8; i++) begin rd_cmd(20 + i); wr_cmd(i, 2'b00, 3); end
    nop(); nop();
    for (int i = 0; i < 8; i++) rd_cmd(i);
    nop(); nop();

    // R9: read right after write to the same address, full and partial lanes
    tag = "R9";
    wr_cmd(3, 2'b00, 4); rd_cmd(3);
    wr_cmd(4, 2'b01, 5); rd_cmd(4);
    wr_cmd(5, 2'b10, 6); rd_cmd(5);
    wr_cmd(6, 2'b00, 7); nop(); rd_cmd(6);
    wr_cmd(7, 2'b10, 8); rd_cmd(7); rd_cmd(7);
    nop(); nop();

    // R1: single-lane writes then readback
    tag = "R1";
    wr_cmd(10, 2'b10, 9); wr_cmd(11, 2'b01, 9); nop(); nop();
    rd_cmd(10); rd_cmd(11); nop(); nop();

    // R4: abort write, storage unchanged
    tag = "R4";
    wr_cmd(12, 2'b11, 10); nop(); nop(); nop();
    rd_cmd(12); wr_cmd(13, 2'b11, 10); rd_cmd(13); nop(); nop();

    // R5: held clock edges inside reads and writes
    tag = "R5";
    rd_cmd(1); hold_cyc(); hold_cyc(); rd_cmd(2); hold_cyc(); nop(); hold_cyc(); nop(); nop();
    wr_cmd(14, 2'b00, 11); hold_cyc(); hold_cyc(); rd_cmd(14); hold_cyc(); nop(); nop(); hold_cyc(); nop();

    // R6: each select input alone deselects
    tag = "R6";
    cs1_n = 1; rd_cmd(1); wr_cmd(1, 2'b00, 12); cs1_n = 0; nop(); nop();
    cs2_n = 1; rd_cmd(2); cs2_n = 0; nop(); nop();
    cs3 = 0; rd_cmd(3); cs3 = 1; rd_cmd(1); nop(); nop();

    // R11: advance high issues nothing
    tag = "R11";
    rd_cmd(2); nop(); nop(); nop(); nop();

    // R7: asynchronous output enable
    tag = "R7";
    rd_cmd(2); rd_cmd(3); rd_cmd(4);
    #1 out_en_n = 1;
    #1 n_chk++;
    if (dq_oe !== 1'b0) begin n_bad++; $display("FAIL R7: dq_oe=%0b expected 0", dq_oe); end
    out_en_n = 0;
    #1 check_now();
    out_en_n = 1; nop(); out_en_n = 0; nop(); nop();

    // R8: sleep keeps storage, resumes on next command
    tag = "R8";
    rd_cmd(5); nop();
    sleep = 1; nop(); nop(); nop();
    sleep = 0; nop();
    rd_cmd(5); rd_cmd(6); nop(); nop();

    // R10: reset mid-run keeps storage
    tag = "R10";
    rd_cmd(7); rst_n = 0; nop(); nop(); rst_n = 1; nop();
    rd_cmd(7); rd_cmd(10); nop(); nop();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule